// File: doc/BRIEF.md
# Triggered Four-Slot Conversion Sequencer

This block sequences an analog-to-digital converter in an externally triggered, buffered mode. Software sets an enable bit and selects one analog channel. From then on each rising edge on an external trigger pin starts exactly one conversion of that channel. The result goes into the next of four result slots, filling slot 0, then 1, then 2, then 3.

Once the fourth slot has been written, the block pulses a conversion-end interrupt and goes idle. The slot index returns to 0, so the next trigger begins a fresh group of four. A typical use is to collect four samples of the same input for averaging by software. The analog converter sits outside the block. It is driven through a one-cycle start pulse and answers with a done strobe that carries a 10-bit result.

Top module: `trigBufAdcSeq`

## Requirements
- R1: After reset, all four result slots read 0, the slot index is 0, and `convStart` and `irqEnd` are low.
- R2: A rising edge on `extTrig` while `enable` is 1 passes through a two-flop synchronizer. It produces a `convStart` pulse exactly one cycle long, first visible in the cycle after the third rising clock edge that follows the trigger change.
- R3: `convChan` equals the `chanSel` value captured when the conversion starts, and it holds steady while that conversion runs.
- R4: Each result presented with `convDone` during a conversion is stored in the current slot. Slots fill in the order 0, 1, 2, 3, and slot k is read on `rdData` when `rdIdx` equals k (binary).
- R5: `irqEnd` is high for exactly one cycle, set by the same clock edge that stores slot 3. The first three conversions of a group raise no interrupt.
- R6: After the fourth conversion no further conversion starts without a new trigger. The next trigger writes slot 0 and leaves the other slots unchanged.
- R7: A trigger edge that arrives while a conversion is in progress is ignored. It starts no extra conversion.
- R8: While `enable` is 0, triggers are ignored. Clearing `enable` aborts a running conversion, so a later `convDone` stores nothing. It also returns the slot index to 0 and leaves stored results unchanged.
- R9: A trigger held high for many cycles counts as a single edge and yields one conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable bit |
| chanSel | input | 3 | Analog channel to convert |
| extTrig | input | 1 | Asynchronous external trigger |
| rdIdx | input | 2 | Result slot to read |
| rdData | output | 10 | Contents of the selected slot |
| convStart | output | 1 | One-cycle start pulse to the converter |
| convChan | output | 3 | Channel presented to the converter |
| convDone | input | 1 | Converter done strobe |
| convResult | input | 10 | Converter result, valid with `convDone` |
| irqEnd | output | 1 | Conversion-end interrupt pulse |

## Verification
A wrong slot index shows up at `rdData` as a result sitting in the wrong slot, or as a neighbour overwritten. It is visible one cycle after the offending done strobe. A stuck or wrong sequencer state shows up as a missing or doubled `convStart` within three cycles of a trigger edge. It can also show as a result stored after an abort, or as an interrupt in the wrong group position. Every check therefore counts start pulses and interrupts and then reads back all four slots.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureChan;
    logic writeRes;
    logic clearIdx;
  } seqStrobe_t;

endpackage

// File: rtl/trigSync.sv
module trigSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseOut
);
  logic [STAGES-1:0] chain;
  logic              lastLevel;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) lastLevel <= 1'b0;
    else       lastLevel <= chain[STAGES-1];
  end

  assign riseOut = chain[STAGES-1] & ~lastLevel;
endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import adcSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       trigRise,
  input  logic       convDone,
  input  logic       lastSlot,
  output seqStrobe_t strobe,
  output logic       convStart,
  output logic       irqEnd
);
  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (!enable) begin
      nextState       = ST_IDLE;
      strobe.clearIdx = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (trigRise) begin
            nextState          = ST_START;
            strobe.captureChan = 1'b1;
          end
        end
        ST_START: nextState = ST_WAIT;
        ST_WAIT: begin
          if (convDone) begin
            strobe.writeRes = 1'b1;
            nextState       = ST_IDLE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      irqEnd <= 1'b0;
    end else begin
      state  <= nextState;
      irqEnd <= strobe.writeRes & lastSlot;
    end
  end

  assign convStart = (state == ST_START);
endmodule

// File: rtl/resultBank.sv
module resultBank
  import adcSeqPkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int RES_W   = 10,
  parameter int CH_W    = 3,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [CH_W-1:0]  chanSel,
  input  logic [RES_W-1:0] convResult,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [CH_W-1:0]  convChan,
  output logic [RES_W-1:0] rdData,
  output logic             lastSlot
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUF - 1);

  logic [IDX_W-1:0] wrIdx;
  logic [RES_W-1:0] slots [NUM_BUF];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
    end else if (strobe.clearIdx) begin
      wrIdx <= '0;
    end else if (strobe.writeRes) begin
      wrIdx <= (wrIdx == LAST_IDX) ? '0 : wrIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  convChan <= '0;
    else if (strobe.captureChan) convChan <= chanSel;
  end

  genvar s;
  generate
    for (s = 0; s < NUM_BUF; s++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN)
          slots[s] <= '0;
        else if (strobe.writeRes && wrIdx == IDX_W'(s))
          slots[s] <= convResult;
      end
    end
  endgenerate

  assign rdData   = slots[rdIdx];
  assign lastSlot = (wrIdx == LAST_IDX);
endmodule

// File: rtl/trigBufAdcSeq.sv
module trigBufAdcSeq
  import adcSeqPkg::*;
#(
  parameter int NUM_BUF   = 4,
  parameter int RES_W     = 10,
  parameter int CH_W      = 3,
  parameter int SYNC_STG  = 2,
  localparam int IDX_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CH_W-1:0]  chanSel,
  input  logic             extTrig,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [RES_W-1:0] rdData,
  output logic             convStart,
  output logic [CH_W-1:0]  convChan,
  input  logic             convDone,
  input  logic [RES_W-1:0] convResult,
  output logic             irqEnd
);
  logic       trigRise;
  logic       lastSlot;
  seqStrobe_t strobe;

  trigSync #(.STAGES(SYNC_STG)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(extTrig), .riseOut(trigRise)
  );

  seqCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .trigRise(trigRise),
    .convDone(convDone), .lastSlot(lastSlot), .strobe(strobe),
    .convStart(convStart), .irqEnd(irqEnd)
  );

  resultBank #(.NUM_BUF(NUM_BUF), .RES_W(RES_W), .CH_W(CH_W)) bank_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chanSel(chanSel),
    .convResult(convResult), .rdIdx(rdIdx), .convChan(convChan),
    .rdData(rdData), .lastSlot(lastSlot)
  );
endmodule

// File: rtl/trigBufAdcSeqChk.sv
module trigBufAdcSeqChk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            enable,
  input logic            convStart,
  input logic            convDone,
  input logic [CH_W-1:0] convChan,
  input logic            irqEnd
);
  p_start_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> $stable(convChan));

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqEnd |=> !irqEnd);

  p_irq_after_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqEnd) |-> ($past(convDone) && $past(enable)));

  p_disable_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!convStart && !irqEnd));
endmodule

bind trigBufAdcSeq trigBufAdcSeqChk #(.CH_W(CH_W)) chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .convStart(convStart),
  .convDone(convDone), .convChan(convChan), .irqEnd(irqEnd)
);

// File: tb/trigBufAdcSeq_tb_top.sv
`timescale 1ns/1ps
module trigBufAdcSeq_tb_top;
  localparam int RES_W = 10;
  localparam int CH_W  = 3;
  localparam int LAT   = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [CH_W-1:0]  chanSel = 3'd5;
  logic             extTrig = 1'b0;
  logic [1:0]       rdIdx = 2'd0;
  logic [RES_W-1:0] rdData;
  logic             convStart;
  logic [CH_W-1:0]  convChan;
  logic             convDone = 1'b0;
  logic [RES_W-1:0] convResult = '0;
  logic             irqEnd;

  int testCount = 0;
  int failCount = 0;
  int startCount = 0;
  int irqCount = 0;
  int cycles = 0;
  int latCnt = 0;
  logic [RES_W-1:0] nextVal = 10'h101;
  logic [RES_W-1:0] expBuf [4];

  always #2.5 clk = ~clk;

  trigBufAdcSeq dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .chanSel(chanSel),
    .extTrig(extTrig), .rdIdx(rdIdx), .rdData(rdData),
    .convStart(convStart), .convChan(convChan), .convDone(convDone),
    .convResult(convResult), .irqEnd(irqEnd)
  );

  // converter model and event monitor
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      latCnt   <= 0;
      convDone <= 1'b0;
    end else begin
      if (convStart) startCount <= startCount + 1;
      if (irqEnd)    irqCount   <= irqCount + 1;
      convDone <= 1'b0;
      if (convStart) latCnt <= LAT;
      else if (latCnt != 0) begin
        latCnt <= latCnt - 1;
        if (latCnt == 1) begin
          convDone   <= 1'b1;
          convResult <= nextVal;
          nextVal    <= nextVal + 10'd37;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic readSlot(input int k, output logic [RES_W-1:0] v);
    @(negedge clk);
    rdIdx = k[1:0];
    #1 v = rdData;
  endtask

  task automatic checkSlots(input string tag);
    logic [RES_W-1:0] v;
    for (int k = 0; k < 4; k++) begin
      readSlot(k, v);
      check(v == expBuf[k], tag, v, expBuf[k]);
    end
  endtask

  task automatic pulseTrig();
    @(negedge clk); extTrig = 1'b1;
    repeat (4) @(negedge clk);
    extTrig = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic runConv(input int slot);
    expBuf[slot] = nextVal;
    pulseTrig();
    repeat (LAT + 8) @(negedge clk);
  endtask

  task automatic tReset();
    check(convStart == 1'b0, "R1 convStart", convStart, 0);
    check(irqEnd == 1'b0, "R1 irqEnd", irqEnd, 0);
    for (int k = 0; k < 4; k++) expBuf[k] = '0;
    checkSlots("R1 slot zero");
  endtask

  task automatic tLatency();
    int n = 0;
    int s0 = startCount;
    expBuf[0] = nextVal;
    @(negedge clk); extTrig = 1'b1;
    while (!convStart && n < 10) begin @(negedge clk); n++; end
    check(n == 3, "R2 start latency", n, 3);
    check(convChan == chanSel, "R3 channel", convChan, chanSel);
    chanSel = 3'd2;
    @(negedge clk);
    check(convStart == 1'b0, "R2 pulse width", convStart, 0);
    check(convChan == 3'd5, "R3 channel held", convChan, 5);
    chanSel = 3'd5;
    repeat (2) @(negedge clk); extTrig = 1'b0;
    repeat (LAT + 8) @(negedge clk);
    check(startCount - s0 == 1, "R2 one start", startCount - s0, 1);
  endtask

  task automatic tFill();
    runConv(1);
    runConv(2);
    check(irqCount == 0, "R5 no irq before fourth", irqCount, 0);
    runConv(3);
    check(irqCount == 1, "R5 irq after fourth", irqCount, 1);
    checkSlots("R4 slot order");
  endtask

  task automatic tWrap();
    int s0 = startCount;
    repeat (30) @(negedge clk);
    check(startCount == s0, "R6 idle without trigger", startCount, s0);
    runConv(0);
    checkSlots("R6 wrap to slot 0");
    check(irqCount == 1, "R6 no extra irq", irqCount, 1);
  endtask

  task automatic tBusyTrig();
    int s0 = startCount;
    expBuf[1] = nextVal;
    pulseTrig();
    pulseTrig();
    repeat (LAT + 8) @(negedge clk);
    check(startCount - s0 == 1, "R7 busy trigger ignored", startCount - s0, 1);
    checkSlots("R7 slots");
  endtask

  task automatic tHeld();
    int s0 = startCount;
    expBuf[2] = nextVal;
    @(negedge clk); extTrig = 1'b1;
    repeat (60) @(negedge clk);
    extTrig = 1'b0;
    repeat (5) @(negedge clk);
    check(startCount - s0 == 1, "R9 held trigger", startCount - s0, 1);
    checkSlots("R9 slots");
  endtask

  task automatic tDisable();
    int s0;
    enable = 1'b0;
    s0 = startCount;
    pulseTrig();
    repeat (10) @(negedge clk);
    check(startCount == s0, "R8 disabled trigger", startCount, s0);
    enable = 1'b1;
    @(negedge clk);
    pulseTrig();
    check(startCount - s0 == 1, "R8 abort start seen", startCount - s0, 1);
    enable = 1'b0;
    repeat (LAT + 8) @(negedge clk);
    checkSlots("R8 abort keeps slots");
    enable = 1'b1;
    @(negedge clk);
    runConv(0);
    checkSlots("R8 index reset");
    check(irqCount == 1, "R8 no irq", irqCount, 1);
  endtask

  always @(negedge clk) begin
    if (cycles == 150000) begin
      failCount++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    enable = 1'b1;
    repeat (2) @(negedge clk);
    tLatency();
    tFill();
    tWrap();
    tBusyTrig();
    tHeld();
    tDisable();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule